// File: doc/BRIEF.md
# Serial LED Status Shifter

This block drives the status indicators of an 8-port switch over three wires: a generated LED clock, an active-low data line and an active-high strobe. Once per frame it takes a copy of five status bits from every port: link, duplex, activity, collision and receive-buffer-full. It shifts the copy out bit by bit on the LED clock. It then raises the strobe so that an external chain of shift registers moves the pattern onto its outputs. Frames follow one another without a gap.

Two pins also serve as configuration straps. While reset is asserted, and on the first clock edge after it is released, the block does not drive the strobe and data pins and reads them as inputs. A strobe strap of 0 makes every port report link up whatever its link input says. A data strap of 1 reports a slow expansion port and 0 a fast one. Short activity and collision events are held until the next frame copy is taken, so each one is shown for at least one whole frame.

Top module: `led_status_serializer`

## Requirements
- R1: While rst_ni is low, and up to the first clock edge after it rises, pin_oe_o, led_clk_o and led_stb_o are all 0.
- R2: led_clk_o is a square wave whose period is 2*HALF_DIV clock cycles. led_dat_o changes only in the cycle in which led_clk_o falls, so it is stable at every rising edge.
- R3: A frame is 40 data bits, with port 7 first and port 0 last. Each port sends, in this order: link, duplex, activity, collision, receive-buffer-full.
- R4: led_dat_o is active low. A status bit of 1 is sent as 0.
- R5: After the 40th bit, led_stb_o is high for exactly one LED clock period and led_dat_o is 1 during that period. Strobes rise every 41 LED clock periods.
- R6: An activity pulse of one clock cycle shows as lit in the next frame copy and is dark again in the frame after that.
- R7: A collision pulse of one clock cycle shows as lit in the next frame copy and is dark again in the frame after that.
- R8: If the strobe pin reads 0 at the capture edge, every link bit is sent as 1. If it reads 1, link_i is sent. The captured value does not change until the next reset.
- R9: The data pin value at the capture edge appears on strap_slow_exp_o (1 = slow expansion port) and is held until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_i | input | NPORTS | Per-port link status |
| fdx_i | input | NPORTS | Per-port full-duplex status |
| act_i | input | NPORTS | Per-port receive/transmit activity |
| col_i | input | NPORTS | Per-port collision |
| bfull_i | input | NPORTS | Per-port receive buffer full |
| stb_pin_i | input | 1 | Strobe pin as read from the pad (strap) |
| dat_pin_i | input | 1 | Data pin as read from the pad (strap) |
| pin_oe_o | output | 1 | Output enable for the strobe and data pads |
| led_clk_o | output | 1 | LED shift clock |
| led_dat_o | output | 1 | Serial LED data, active low |
| led_stb_o | output | 1 | Latch strobe, active high |
| strap_force_link_o | output | 1 | 1 when the strobe strap forces link up |
| strap_slow_exp_o | output | 1 | Captured data-pin strap |

## Verification
Two events can fall in the same cycle: a one-cycle activity or collision pulse, and the frame copy that is taken as the strobe period ends. The bench places such a pulse a few cycles after a strobe is latched, inside the strobe period and just before the copy. The pulse must appear in exactly one latched frame and be gone from the next. It is judged from the pattern the bench latches with its own model of the external shift register.

// File: rtl/led_pkg.sv
`timescale 1ns/1ps
package led_pkg;
  localparam int unsigned FIELDS  = 5;
  // bit position inside a port's 5-bit group, MSB shifted first
  localparam int unsigned F_LINK  = 4;
  localparam int unsigned F_FDX   = 3;
  localparam int unsigned F_ACT   = 2;
  localparam int unsigned F_COL   = 1;
  localparam int unsigned F_BFULL = 0;
endpackage

// File: rtl/led_strap_capture.sv
`timescale 1ns/1ps
module led_strap_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_pin_i,
  input  logic dat_pin_i,
  output logic open_o,
  output logic force_link_o,
  output logic slow_exp_o
);
  logic open_q, stb_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b1;
    else         open_q <= 1'b0;
  end

  // sampled on every edge inside reset and on the first one after it
  always_ff @(posedge clk_i) begin
    if (open_q) begin
      stb_q <= stb_pin_i;
      dat_q <= dat_pin_i;
    end
  end

  assign open_o       = open_q;
  assign force_link_o = ~stb_q;
  assign slow_exp_o   = dat_q;
endmodule

// File: rtl/led_clk_gen.sv
`timescale 1ns/1ps
module led_clk_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic led_clk_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          lclk_q;
  logic          wrap;

  assign wrap = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lclk_q <= 1'b0;
    end else if (en_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        lclk_q <= ~lclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign led_clk_o = lclk_q;
  assign fall_o    = wrap && lclk_q;
endmodule

// File: rtl/led_status_stretch.sv
`timescale 1ns/1ps
module led_status_stretch
  import led_pkg::*;
#(
  parameter int unsigned NPORTS = 8,
  localparam int unsigned FRAME_BITS = NPORTS * FIELDS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  force_link_i,
  input  logic [NPORTS-1:0]     link_i,
  input  logic [NPORTS-1:0]     fdx_i,
  input  logic [NPORTS-1:0]     act_i,
  input  logic [NPORTS-1:0]     col_i,
  input  logic [NPORTS-1:0]     bfull_i,
  output logic [FRAME_BITS-1:0] status_o
);
  logic [NPORTS-1:0] act_hold_q, col_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_hold_q <= '0;
      col_hold_q <= '0;
    end else if (load_i) begin
      act_hold_q <= '0;
      col_hold_q <= '0;
    end else begin
      act_hold_q <= act_hold_q | act_i;
      col_hold_q <= col_hold_q | col_i;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign status_o[p*FIELDS + F_LINK]  = link_i[p] | force_link_i;
    assign status_o[p*FIELDS + F_FDX]   = fdx_i[p];
    assign status_o[p*FIELDS + F_ACT]   = act_i[p] | act_hold_q[p];
    assign status_o[p*FIELDS + F_COL]   = col_i[p] | col_hold_q[p];
    assign status_o[p*FIELDS + F_BFULL] = bfull_i[p];
  end
endmodule

// File: rtl/led_frame_shifter.sv
`timescale 1ns/1ps
module led_frame_shifter #(
  parameter int unsigned FRAME_BITS = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fall_i,
  input  logic [FRAME_BITS-1:0] status_i,
  output logic                  load_o,
  output logic                  dat_o,
  output logic                  stb_o
);
  localparam int unsigned IW = $clog2(FRAME_BITS + 1);
  localparam logic [IW-1:0] STB_SLOT = IW'(FRAME_BITS);

  logic [IW-1:0]         idx_q;
  logic [FRAME_BITS-1:0] sreg_q;
  logic                  in_slot;

  assign in_slot = (idx_q == STB_SLOT);
  assign load_o  = fall_i && in_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      sreg_q <= '0;
    end else if (fall_i) begin
      if (in_slot) begin
        idx_q  <= '0;
        sreg_q <= status_i;
      end else begin
        idx_q  <= idx_q + 1'b1;
        sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign dat_o = in_slot ? 1'b1 : ~sreg_q[FRAME_BITS-1];
  assign stb_o = in_slot;
endmodule

// File: rtl/led_status_serializer.sv
`timescale 1ns/1ps
module led_status_serializer
  import led_pkg::*;
#(
  parameter int unsigned NPORTS   = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPORTS-1:0] link_i,
  input  logic [NPORTS-1:0] fdx_i,
  input  logic [NPORTS-1:0] act_i,
  input  logic [NPORTS-1:0] col_i,
  input  logic [NPORTS-1:0] bfull_i,
  input  logic              stb_pin_i,
  input  logic              dat_pin_i,
  output logic              pin_oe_o,
  output logic              led_clk_o,
  output logic              led_dat_o,
  output logic              led_stb_o,
  output logic              strap_force_link_o,
  output logic              strap_slow_exp_o
);
  localparam int unsigned FRAME_BITS = NPORTS * FIELDS;

  logic                  strap_open, force_link, fall, load, stb_raw;
  logic [FRAME_BITS-1:0] status;

  led_strap_capture i_strap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stb_pin_i    (stb_pin_i),
    .dat_pin_i    (dat_pin_i),
    .open_o       (strap_open),
    .force_link_o (force_link),
    .slow_exp_o   (strap_slow_exp_o)
  );

  led_clk_gen #(.HALF_DIV(HALF_DIV)) i_clk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (~strap_open),
    .led_clk_o (led_clk_o),
    .fall_o    (fall)
  );

  led_status_stretch #(.NPORTS(NPORTS)) i_stretch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .force_link_i (force_link),
    .link_i       (link_i),
    .fdx_i        (fdx_i),
    .act_i        (act_i),
    .col_i        (col_i),
    .bfull_i      (bfull_i),
    .status_o     (status)
  );

  led_frame_shifter #(.FRAME_BITS(FRAME_BITS)) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .status_i (status),
    .load_o   (load),
    .dat_o    (led_dat_o),
    .stb_o    (stb_raw)
  );

  assign pin_oe_o           = ~strap_open;
  assign led_stb_o          = stb_raw & ~strap_open;
  assign strap_force_link_o = force_link;
endmodule

// File: rtl/led_status_serializer_chk.sv
`timescale 1ns/1ps
module led_status_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_oe_o,
  input logic led_clk_o,
  input logic led_dat_o,
  input logic led_stb_o,
  input logic strap_force_link_o,
  input logic strap_slow_exp_o
);
  AST_IDLE_UNTIL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> (!led_clk_o && !led_stb_o)); // R1
  AST_DAT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_dat_o) |-> $fell(led_clk_o)); // R2
  AST_STB_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_stb_o) |-> $fell(led_clk_o)); // R5
  AST_STB_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_stb_o |-> led_dat_o); // R5
  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o && $past(pin_oe_o)) |-> ($stable(strap_force_link_o) && $stable(strap_slow_exp_o))); // R8 R9
endmodule

bind led_status_serializer led_status_serializer_chk i_chk (.*);

// File: tb/test_led_status_serializer.sv
`timescale 1ns/1ps
module test_led_status_serializer;
  localparam int unsigned NP   = 8;
  localparam int unsigned HALF = 4;
  localparam int unsigned FB   = NP * 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] link, fdx, act, col, bfull;
  logic stb_pin, dat_pin;
  logic pin_oe, lclk, ldat, lstb, force_link, slow_exp;

  always #2.5 clk = ~clk;

  led_status_serializer #(.NPORTS(NP), .HALF_DIV(HALF)) i_led_status_serializer (
    .clk_i(clk), .rst_ni(rst_n), .link_i(link), .fdx_i(fdx), .act_i(act),
    .col_i(col), .bfull_i(bfull), .stb_pin_i(stb_pin), .dat_pin_i(dat_pin),
    .pin_oe_o(pin_oe), .led_clk_o(lclk), .led_dat_o(ldat), .led_stb_o(lstb),
    .strap_force_link_o(force_link), .strap_slow_exp_o(slow_exp)
  );

  int n_vec = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // model of the external shift register and latch
  logic [FB-1:0] shreg = '0, latched = '0;
  int latch_cnt = 0, rise_per = 0, last_rise = 0;
  int stb_rise = 0, stb_per = 0, stb_width = 0, bad_dat_edge = 0;
  logic p_lclk = 1'b0, p_dat = 1'b1, p_stb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ldat != p_dat && !(p_lclk && !lclk)) bad_dat_edge++;
      if (!p_lclk && lclk) begin
        rise_per  = cyc - last_rise;
        last_rise = cyc;
        if (lstb) begin
          latched = shreg;
          latch_cnt++;
        end else shreg = {shreg[FB-2:0], ldat};
      end
      if (!p_stb && lstb) begin stb_per = cyc - stb_rise; stb_rise = cyc; end
      if (p_stb && !lstb) stb_width = cyc - stb_rise;
    end
    p_lclk = lclk; p_dat = ldat; p_stb = lstb;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [FB-1:0] frame_of(input logic [NP-1:0] lk, fd, ac, cl, bf);
    logic [FB-1:0] f;
    for (int p = 0; p < NP; p++) begin
      f[p*5+4] = lk[p]; f[p*5+3] = fd[p]; f[p*5+2] = ac[p];
      f[p*5+1] = cl[p]; f[p*5+0] = bf[p];
    end
    return f;
  endfunction

  task automatic wait_latch();
    int c = latch_cnt;
    wait (latch_cnt != c);
  endtask

  task automatic do_reset(input logic s_stb, input logic s_dat);
    rst_n = 1'b0; stb_pin = s_stb; dat_pin = s_dat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pin_oe && !lclk && !lstb, "R1 idle in reset", {61'd0, pin_oe, lclk, lstb}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    stb_pin = ~s_stb; dat_pin = ~s_dat;
    repeat (4) @(negedge clk);
    chk(pin_oe, "R1 pins driven after capture", {63'd0, pin_oe}, 64'd1);
  endtask

  // {link, fdx, act, col, bfull}
  localparam logic [39:0] VEC [6] = '{
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'hA5, 8'h3C, 8'h00, 8'h00, 8'h81},
    {8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    {8'h80, 8'h01, 8'h02, 8'h04, 8'h08},
    {8'h5A, 8'hC3, 8'h18, 8'h24, 8'h42},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  initial begin
    link = '0; fdx = '0; act = '0; col = '0; bfull = '0;
    do_reset(1'b1, 1'b1);
    chk(!force_link, "R8 strap 1 passes link", {63'd0, force_link}, 64'd0);
    chk(slow_exp, "R9 slow strap", {63'd0, slow_exp}, 64'd1);

    for (int v = 0; v < 6; v++) begin
      {link, fdx, act, col, bfull} = VEC[v];
      repeat (3) wait_latch();
      // R3 order, R4 active low
      chk(latched == ~frame_of(link, fdx, act, col, bfull), "R3 R4 frame",
          64'(latched), 64'(~frame_of(link, fdx, act, col, bfull)));
    end

    chk(rise_per == 2*HALF, "R2 led clock period", 64'(rise_per), 64'(2*HALF));
    chk(bad_dat_edge == 0, "R2 data moves on fall only", 64'(bad_dat_edge), 64'd0);
    chk(stb_width == 2*HALF, "R5 strobe width", 64'(stb_width), 64'(2*HALF));
    chk(stb_per == (FB+1)*2*HALF, "R5 frame period", 64'(stb_per), 64'((FB+1)*2*HALF));

    // R6: one-cycle activity pulse placed next to the frame copy
    link = 8'hFF; fdx = '0; act = '0; col = '0; bfull = '0;
    repeat (3) wait_latch();
    @(posedge clk); #1 act[3] = 1'b1;
    @(posedge clk); #1 act[3] = 1'b0;
    wait_latch();
    chk(latched[3*5+2] == 1'b0, "R6 activity stretched", 64'(latched[3*5+2]), 64'd0);
    wait_latch();
    chk(latched[3*5+2] == 1'b1, "R6 activity cleared", 64'(latched[3*5+2]), 64'd1);

    // R7: one-cycle collision pulse in the middle of a frame
    wait_latch();
    repeat (100) @(posedge clk);
    #1 col[6] = 1'b1;
    @(posedge clk); #1 col[6] = 1'b0;
    wait_latch();
    wait_latch();
    chk(latched[6*5+1] == 1'b0, "R7 collision stretched", 64'(latched[6*5+1]), 64'd0);
    wait_latch();
    chk(latched[6*5+1] == 1'b1, "R7 collision cleared", 64'(latched[6*5+1]), 64'd1);

    // R8/R9 with both straps low
    do_reset(1'b0, 1'b0);
    chk(force_link, "R8 strap 0 forces link", {63'd0, force_link}, 64'd1);
    chk(!slow_exp, "R9 fast strap", {63'd0, slow_exp}, 64'd0);
    link = 8'h00; fdx = 8'h0F; act = '0; col = '0; bfull = 8'h30;
    repeat (3) wait_latch();
    chk(latched == ~frame_of(8'hFF, fdx, act, col, bfull), "R8 forced link frame",
        64'(latched), 64'(~frame_of(8'hFF, fdx, act, col, bfull)));
    chk(force_link && !slow_exp, "R8 R9 straps held", {62'd0, force_link, slow_exp}, 64'd2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule